// File: doc/BRIEF.md
# Multifunction Barrel Shifter

This unit is the shifting stage of a 16-bit fixed-point datapath. Each issued operation takes a 16-bit operand, places it in the upper or lower half of a 32-bit field, shifts that field by a signed amount, and writes the outcome into a 32-bit result register. The shift can be logical or arithmetic. A merge flag ORs the new value into the current result, so a number wider than one word is assembled from several operations.

Besides plain shifts, the unit measures how many redundant sign bits an operand carries and stores that as an exponent. It normalizes an operand by that exponent. It also shifts an operand back to a common scale using the stored exponent, which can be loaded directly. For block floating-point work, a separate register keeps the smallest redundant-sign count seen across a series of words. A dedicated operation clears that register.

Every operation is issued with a one-cycle `go` strobe. Its effect shows on the outputs after the next rising clock edge.

Top module: `shift_engine`

## Requirements
- R1: After reset, `result` is 0, `exponent` is 0 and `blk_exp` is -15.
- R2: Op code 0 is a logical shift. The operand goes to bits 31:16 when `hi` is 1, or to bits 15:0 when `hi` is 0, with zeros elsewhere. A positive `amt` shifts left, a negative `amt` shifts right, and vacated bits are filled with zeros.
- R3: Op code 1 is an arithmetic shift. It behaves like op code 0, with two differences. Bits vacated by a right shift take operand bit 15. In low placement, bits 31:16 also take operand bit 15.
- R4: When the effective shift magnitude is 32 or more, every result bit is the fill bit. A left shift gives all zeros. A right shift gives all zeros (logical) or all copies of operand bit 15 (arithmetic).
- R5: For op codes 0 to 3 with `merge` set, the new shifted value is ORed with the current result instead of replacing it.
- R6: Op code 4 sets `exponent` to minus the number of bits below bit 15 that equal bit 15 before the first differing bit. An operand of 0x0000 or 0xFFFF gives -15. `result` is left unchanged.
- R7: Op code 2 normalizes: an arithmetic shift of the placed operand by minus the current `exponent`, so a left shift for a non-positive exponent.
- R8: Op code 3 denormalizes: an arithmetic shift of the placed operand by the current `exponent`, so a right shift for a negative exponent.
- R9: Op code 7 loads `amt` into `exponent` and leaves `result` unchanged.
- R10: Op code 5 lowers the stored block count to the operand's redundant-sign count when that count is smaller. Op code 6 resets the block count to 15. `blk_exp` shows minus the block count. Neither op code changes `result` or `exponent`.
- R11: Outputs change only on the rising clock edge after a cycle with `go` high. With `go` low, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Issue strobe for one operation |
| op | input | 3 | Operation code (0 lsh, 1 ash, 2 norm, 3 denorm, 4 exp, 5 blk update, 6 blk clear, 7 load exp) |
| operand | input | 16 | Fixed-point input word |
| amt | input | 8 | Signed shift amount or exponent to load |
| hi | input | 1 | 1 places the operand at bits 31:16, 0 at bits 15:0 |
| merge | input | 1 | 1 ORs the shifted value into the result |
| result | output | 32 | Result register |
| exponent | output | 8 | Signed stored exponent |
| blk_exp | output | 8 | Signed block exponent (minus the running minimum count) |

## Verification
The bench uses the default build: 16-bit data, a 32-bit result field and 8-bit signed amounts. This makes the ±32 magnitude boundary reachable from the `amt` port directly, and lets every exponent from 0 to -15 be produced by chosen operands. The directed tasks assemble a two-word value through merge, cover both halves and both fill kinds at and just beyond the field width, and chain exponent derivation into normalize and denormalize. They also walk the block minimum down and clear it again.

// File: rtl/shift_engine_pkg.sv
package shift_engine_pkg;

    typedef enum logic [2:0] {
        OP_LSH    = 3'd0,
        OP_ASH    = 3'd1,
        OP_NORM   = 3'd2,
        OP_DENORM = 3'd3,
        OP_EXP    = 3'd4,
        OP_BLKUPD = 3'd5,
        OP_BLKCLR = 3'd6,
        OP_LDEXP  = 3'd7
    } sh_op_e;

endpackage

// File: rtl/sign_run_counter.sv
module sign_run_counter #(
    parameter int DATA_W = 16,
    localparam int CNT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] word,
    output logic [CNT_W-1:0]  count
);
    always_comb begin
        logic stop;
        stop  = 1'b0;
        count = '0;
        for (int i = DATA_W - 2; i >= 0; i--) begin
            if (!stop && (word[i] == word[DATA_W-1])) begin
                count = count + 1'b1;
            end else begin
                stop = 1'b1;
            end
        end
    end
endmodule

// File: rtl/operand_placer.sv
module operand_placer #(
    parameter int DATA_W = 16,
    localparam int RES_W = 2 * DATA_W
) (
    input  logic [DATA_W-1:0] word,
    input  logic              hi,
    input  logic              arith,
    output logic [RES_W-1:0]  field,
    output logic              fill
);
    always_comb begin
        fill = arith & word[DATA_W-1];
        if (hi) begin
            field = {word, {DATA_W{1'b0}}};
        end else begin
            field = {{DATA_W{fill}}, word};
        end
    end
endmodule

// File: rtl/field_shifter.sv
module field_shifter #(
    parameter int RES_W = 32,
    parameter int SH_W  = 9,
    localparam int IDX_W = $clog2(RES_W)
) (
    input  logic [RES_W-1:0]       field,
    input  logic                   fill,
    input  logic signed [SH_W-1:0] amt,
    output logic [RES_W-1:0]       shifted
);
    logic [SH_W:0]         mag;
    logic                  too_far;
    logic [IDX_W-1:0]      idx;
    logic signed [RES_W:0] ext_in;
    logic signed [RES_W:0] ext_out;

    always_comb begin
        if (amt[SH_W-1]) begin
            mag = -{amt[SH_W-1], amt};
        end else begin
            mag = {1'b0, amt};
        end
        too_far = (mag >= (SH_W+1)'(RES_W));
        idx     = mag[IDX_W-1:0];
        ext_in  = $signed({fill, field});
        ext_out = ext_in >>> idx;
        if (!amt[SH_W-1]) begin
            shifted = too_far ? '0 : (field << idx);
        end else begin
            shifted = too_far ? {RES_W{fill}} : ext_out[RES_W-1:0];
        end
    end
endmodule

// File: rtl/shift_engine.sv
module shift_engine
    import shift_engine_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int AMT_W  = 8,
    localparam int RES_W = 2 * DATA_W,
    localparam int CNT_W = $clog2(DATA_W),
    localparam int SH_W  = AMT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [2:0]       op,
    input  logic [DATA_W-1:0] operand,
    input  logic [AMT_W-1:0] amt,
    input  logic             hi,
    input  logic             merge,
    output logic [RES_W-1:0] result,
    output logic [AMT_W-1:0] exponent,
    output logic [AMT_W-1:0] blk_exp
);
    typedef struct packed {
        logic [RES_W-1:0] res;
        logic [AMT_W-1:0] expo;
        logic [CNT_W-1:0] blk;
    } eng_state_t;

    localparam logic [CNT_W-1:0] BLK_MAX = CNT_W'(DATA_W - 1);

    eng_state_t state_d, state_q;
    sh_op_e     op_e;

    logic [CNT_W-1:0]       run_cnt;
    logic [RES_W-1:0]       placed;
    logic                   fill_bit;
    logic                   arith;
    logic signed [SH_W-1:0] sh_amt;
    logic [RES_W-1:0]       shifted;

    assign op_e  = sh_op_e'(op);
    assign arith = (op_e != OP_LSH);

    sign_run_counter #(.DATA_W(DATA_W)) u_count (
        .word  (operand),
        .count (run_cnt)
    );

    operand_placer #(.DATA_W(DATA_W)) u_place (
        .word  (operand),
        .hi    (hi),
        .arith (arith),
        .field (placed),
        .fill  (fill_bit)
    );

    always_comb begin
        unique case (op_e)
            OP_NORM:   sh_amt = -$signed({state_q.expo[AMT_W-1], state_q.expo});
            OP_DENORM: sh_amt = $signed({state_q.expo[AMT_W-1], state_q.expo});
            default:   sh_amt = $signed({amt[AMT_W-1], amt});
        endcase
    end

    field_shifter #(.RES_W(RES_W), .SH_W(SH_W)) u_shift (
        .field   (placed),
        .fill    (fill_bit),
        .amt     (sh_amt),
        .shifted (shifted)
    );

    always_comb begin
        state_d = state_q;
        if (go) begin
            unique case (op_e)
                OP_LSH, OP_ASH, OP_NORM, OP_DENORM: begin
                    state_d.res = merge ? (state_q.res | shifted) : shifted;
                end
                OP_EXP: begin
                    state_d.expo = -AMT_W'(run_cnt);
                end
                OP_BLKUPD: begin
                    if (run_cnt < state_q.blk) begin
                        state_d.blk = run_cnt;
                    end
                end
                OP_BLKCLR: begin
                    state_d.blk = BLK_MAX;
                end
                OP_LDEXP: begin
                    state_d.expo = amt;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.res  <= '0;
            state_q.expo <= '0;
            state_q.blk  <= BLK_MAX;
        end else begin
            state_q <= state_d;
        end
    end

    assign result   = state_q.res;
    assign exponent = state_q.expo;
    assign blk_exp  = -AMT_W'(state_q.blk);

endmodule

// File: rtl/shift_engine_chk.sv
module shift_engine_chk #(
    parameter int DATA_W = 16,
    parameter int AMT_W  = 8,
    localparam int RES_W = 2 * DATA_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             go,
    input logic [2:0]       op,
    input logic [AMT_W-1:0] amt,
    input logic             merge,
    input logic [RES_W-1:0] result,
    input logic [AMT_W-1:0] exponent,
    input logic [AMT_W-1:0] blk_exp
);
    localparam logic [2:0] C_EXP    = 3'd4;
    localparam logic [2:0] C_BLKUPD = 3'd5;
    localparam logic [2:0] C_BLKCLR = 3'd6;
    localparam logic [2:0] C_LDEXP  = 3'd7;
    localparam logic [AMT_W-1:0] BLK_RST = -AMT_W'(DATA_W - 1);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> ($stable(result) && $stable(exponent) && $stable(blk_exp)));

    // R6
    exp_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op == C_EXP) |=> $stable(result));

    // R6
    exp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op == C_EXP) |=> ($signed(exponent) <= 0 && $signed(exponent) >= -$signed(AMT_W'(DATA_W - 1))));

    // R9
    load_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op == C_LDEXP) |=> (exponent == $past(amt) && $stable(result)));

    // R10
    blk_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op == C_BLKUPD) |=> ($signed(blk_exp) >= $signed($past(blk_exp)) && $stable(exponent)));

    // R10
    blk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op == C_BLKCLR) |=> (blk_exp == BLK_RST));

    // R5
    merge_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && merge && op[2] == 1'b0) |=> ((result & $past(result)) == $past(result)));

endmodule

bind shift_engine shift_engine_chk #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .op       (op),
    .amt      (amt),
    .merge    (merge),
    .result   (result),
    .exponent (exponent),
    .blk_exp  (blk_exp)
);

// File: tb/shift_engine_bench.sv
module shift_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [15:0] operand = 16'h0;
    logic [7:0]  amt = 8'h0;
    logic        hi = 1'b0;
    logic        merge = 1'b0;
    logic [31:0] result;
    logic [7:0]  exponent;
    logic [7:0]  blk_exp;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    shift_engine u_shift_engine (
        .clk(clk), .rst_n(rst_n), .go(go), .op(op), .operand(operand),
        .amt(amt), .hi(hi), .merge(merge), .result(result),
        .exponent(exponent), .blk_exp(blk_exp)
    );

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s result act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s value act=%h exp=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge, register at the next rising edge, sample at the falling edge after
    task automatic issue(input logic [2:0] o, input logic [15:0] x, input logic [7:0] a,
                         input logic h, input logic m);
        @(negedge clk);
        go = 1'b1; op = o; operand = x; amt = a; hi = h; merge = m;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic t_reset;
        check32("R1", result, 32'h0);
        check8("R1", exponent, 8'h00);
        check8("R1", blk_exp, 8'hF1);
    endtask

    task automatic t_logical;
        issue(3'd0, 16'h1234, 8'd0, 1'b1, 1'b0);  check32("R2", result, 32'h1234_0000);
        issue(3'd0, 16'h8001, 8'd4, 1'b0, 1'b0);  check32("R2", result, 32'h0008_0010);
        issue(3'd0, 16'h8001, -8'sd4, 1'b1, 1'b0); check32("R2", result, 32'h0800_1000);
    endtask

    task automatic t_arith;
        issue(3'd1, 16'h8001, -8'sd4, 1'b1, 1'b0); check32("R3", result, 32'hF800_1000);
        issue(3'd1, 16'h8000, 8'd0, 1'b0, 1'b0);   check32("R3", result, 32'hFFFF_8000);
        issue(3'd1, 16'h4000, -8'sd2, 1'b0, 1'b0); check32("R3", result, 32'h0000_1000);
    endtask

    task automatic t_range;
        issue(3'd1, 16'h8000, -8'sd40, 1'b1, 1'b0);  check32("R4", result, 32'hFFFF_FFFF);
        issue(3'd0, 16'hFFFF, 8'd32, 1'b0, 1'b0);    check32("R4", result, 32'h0);
        issue(3'd1, 16'h7FFF, -8'sd100, 1'b1, 1'b0); check32("R4", result, 32'h0);
        issue(3'd0, 16'h0001, 8'd31, 1'b0, 1'b0);    check32("R4", result, 32'h8000_0000);
        issue(3'd0, 16'h8000, -8'sd32, 1'b1, 1'b0);  check32("R4", result, 32'h0);
    endtask

    task automatic t_merge;
        issue(3'd0, 16'h1234, 8'd0, 1'b1, 1'b0); check32("R5", result, 32'h1234_0000);
        issue(3'd0, 16'hABCD, 8'd0, 1'b0, 1'b1); check32("R5", result, 32'h1234_ABCD);
        issue(3'd0, 16'h00F0, 8'd8, 1'b0, 1'b1); check32("R5", result, 32'h1234_FBCD);
    endtask

    task automatic t_exp;
        issue(3'd4, 16'h0000, 8'd0, 1'b0, 1'b0); check8("R6", exponent, 8'hF1);
        check32("R6", result, 32'h1234_FBCD);
        issue(3'd4, 16'hFFFF, 8'd0, 1'b0, 1'b0); check8("R6", exponent, 8'hF1);
        issue(3'd4, 16'h4000, 8'd0, 1'b0, 1'b0); check8("R6", exponent, 8'h00);
        issue(3'd4, 16'hC000, 8'd0, 1'b0, 1'b0); check8("R6", exponent, 8'hFF);
        issue(3'd4, 16'h0100, 8'd0, 1'b0, 1'b0); check8("R6", exponent, 8'hFA);
    endtask

    task automatic t_norm;
        issue(3'd2, 16'h0100, 8'd0, 1'b1, 1'b0); check32("R7", result, 32'h4000_0000);
        issue(3'd2, 16'h0100, 8'd0, 1'b0, 1'b0); check32("R7", result, 32'h0000_4000);
    endtask

    task automatic t_denorm;
        issue(3'd7, 16'h0000, -8'sd3, 1'b0, 1'b0); check8("R9", exponent, 8'hFD);
        check32("R9", result, 32'h0000_4000);
        issue(3'd3, 16'h8000, 8'd0, 1'b1, 1'b0);   check32("R8", result, 32'hF000_0000);
        issue(3'd3, 16'h4000, 8'd0, 1'b0, 1'b0);   check32("R8", result, 32'h0000_0800);
    endtask

    task automatic t_block;
        issue(3'd6, 16'h0000, 8'd0, 1'b0, 1'b0); check8("R10", blk_exp, 8'hF1);
        issue(3'd5, 16'h0100, 8'd0, 1'b0, 1'b0); check8("R10", blk_exp, 8'hFA);
        issue(3'd5, 16'h0001, 8'd0, 1'b0, 1'b0); check8("R10", blk_exp, 8'hFA);
        issue(3'd5, 16'hC000, 8'd0, 1'b0, 1'b0); check8("R10", blk_exp, 8'hFF);
        check8("R10", exponent, 8'hFD);
        check32("R10", result, 32'h0000_0800);
        issue(3'd6, 16'h0000, 8'd0, 1'b0, 1'b0); check8("R10", blk_exp, 8'hF1);
    endtask

    task automatic t_idle;
        @(negedge clk);
        go = 1'b0; op = 3'd0; operand = 16'hFFFF; amt = 8'd5; hi = 1'b1; merge = 1'b0;
        repeat (3) @(negedge clk);
        check32("R11", result, 32'h0000_0800);
        check8("R11", exponent, 8'hFD);
        op = 3'd7;
        repeat (2) @(negedge clk);
        check8("R11", exponent, 8'hFD);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_logical;
        t_arith;
        t_range;
        t_merge;
        t_exp;
        t_norm;
        t_denorm;
        t_block;
        t_idle;
        finished = 1'b1;
    end

    initial begin
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule